// File: doc/BRIEF.md
# PCS Management Register File

This block gives a host processor byte-wide access to the management registers of a physical coding sublayer: control, status, advertised ability, link partner ability, auto-negotiation expansion and extended status. Each 16-bit register occupies two consecutive byte addresses, with the low byte at the even address. The control register drives the sublayer's mode outputs. The advertised ability bytes form a 16-bit ability word for the negotiation logic. Status inputs from the sublayer are presented on reads, either live or through latches that hold an event until software has seen it.

The host starts a transfer by pulling its select low and holds address, direction and write data until the block answers with a one-cycle active-low ready. Write data is accepted on the first clock edge that sees the select low. Read data is valid on the output bus while ready is low, and it stays there until the next read. Each select assertion produces exactly one access. The select must return high before the next access can begin.

Top module: `pcs_mgmt_regs`

## Requirements
- R1: A transfer is performed on the first rising edge at which `host_cs_n` is low. `host_rdy_n` is low for exactly the following cycle. No further access occurs until `host_cs_n` has been high for at least one edge.
- R2: Constant bits read as follows. Address 0x03 reads 0x01. Address 0x1E reads 0x00 and address 0x1F reads 0x80. At 0x00, bit 6 reads 1. At 0x01, bit 5 reads 0. At 0x02, bit 3 reads 1.
- R3: Address 0x01 holds read/write control bits, each driving an output: bit 6 loopback, bit 4 auto-negotiation enable, bit 3 power down, bit 2 isolate, bit 0 duplex.
- R4: Bit 7 (reset) and bit 1 (restart negotiation) of address 0x01 are self-clearing. Writing 1 raises the matching output for exactly one cycle; afterwards the output is 0 and the bit reads 0.
- R5: Bit 5 of address 0x00 is a read/write unidirectional enable driving `ctl_unidir`. Every other bit of 0x00 except bit 6 reads 0.
- R6: Addresses 0x08 (low) and 0x09 (high) are read/write and drive `adv_ability`, with 0x09 forming bits 15:8.
- R7: Addresses 0x0A and 0x0B read the live `lp_ability` low and high bytes.
- R8: Bit 2 of address 0x02 is a latched link status. Any cycle with `st_link_ok` low clears it. A read of 0x02 returns the latched value and reloads the latch from `st_link_ok` in the same edge, so it stays 0 while the link is down.
- R9: Bit 5 of address 0x02 shows `st_an_done` live.
- R10: Bit 1 of address 0x0C latches 1 on any cycle with `st_page_rx` high. A read of 0x0C returns the latched value and reloads the latch from `st_page_rx`. Address 0x0D reads 0x00.
- R11: A write to a read-only, constant or unmapped address is acknowledged but changes no state. An unmapped address reads 0x00.
- R12: After reset, `ctl_an_enable` equals parameter `AN_EN_RST` (default 1). All other control outputs, `adv_ability` and the link/page latches are 0, and `host_rdy_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for host bus and registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_n | input | 1 | Active-low select, held until ready |
| host_wr_n | input | 1 | Active-low write, high for read |
| host_addr | input | ADDR_W | Byte address |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data, valid while ready is low |
| host_rdy_n | output | 1 | Active-low one-cycle transfer acknowledge |
| ctl_reset | output | 1 | Self-clearing sublayer reset pulse |
| ctl_loopback | output | 1 | Loopback enable |
| ctl_an_enable | output | 1 | Auto-negotiation enable |
| ctl_power_down | output | 1 | Power down |
| ctl_isolate | output | 1 | Isolate |
| ctl_an_restart | output | 1 | Self-clearing negotiation restart pulse |
| ctl_duplex | output | 1 | Duplex setting |
| ctl_unidir | output | 1 | Unidirectional mode enable |
| adv_ability | output | ABIL_W | Advertised ability word |
| st_link_ok | input | 1 | Live link status |
| st_an_done | input | 1 | Auto-negotiation complete |
| st_page_rx | input | 1 | Page received event |
| lp_ability | input | ABIL_W | Link partner ability word |

## Verification
The hardest case to reach is the interaction of a latch with its clearing read. This covers a link that fails and recovers between two reads, and a link that is still down while its status is read. The bench reaches it by pulsing `st_link_ok` low for a single cycle between transfers, and by holding it low across a read, then reading twice. A one-cycle `st_page_rx` pulse is handled the same way. For the self-clearing bits, the outputs are sampled in the very cycle ready is low and again one cycle later. For the handshake, select is held low past the ready cycle to show that no second access starts.

// File: rtl/pcs_mgmt_pkg.sv
package pcs_mgmt_pkg;
   localparam int MAP_AW = 6;
   localparam logic [MAP_AW-1:0] A_CTL_LO  = 6'h00;
   localparam logic [MAP_AW-1:0] A_CTL_HI  = 6'h01;
   localparam logic [MAP_AW-1:0] A_STS_LO  = 6'h02;
   localparam logic [MAP_AW-1:0] A_STS_HI  = 6'h03;
   localparam logic [MAP_AW-1:0] A_ADV_LO  = 6'h08;
   localparam logic [MAP_AW-1:0] A_ADV_HI  = 6'h09;
   localparam logic [MAP_AW-1:0] A_LP_LO   = 6'h0A;
   localparam logic [MAP_AW-1:0] A_LP_HI   = 6'h0B;
   localparam logic [MAP_AW-1:0] A_EXP_LO  = 6'h0C;
   localparam logic [MAP_AW-1:0] A_EXP_HI  = 6'h0D;
   localparam logic [MAP_AW-1:0] A_XST_LO  = 6'h1E;
   localparam logic [MAP_AW-1:0] A_XST_HI  = 6'h1F;
   // control high byte bit positions
   localparam int B_RST  = 7;
   localparam int B_LOOP = 6;
   localparam int B_ANEN = 4;
   localparam int B_PD   = 3;
   localparam int B_ISO  = 2;
   localparam int B_RSAN = 1;
   localparam int B_DUP  = 0;
   localparam logic [7:0] CTL_HI_RW = 8'hDF;
   localparam logic [7:0] CTL_HI_SC = 8'h82;
   // control low byte
   localparam int B_UNI  = 5;
   localparam logic [7:0] CTL_LO_CONST = 8'h40;
   // status low byte
   localparam int B_LINK = 2;
   localparam int B_AND  = 5;
   localparam logic [7:0] STS_LO_CONST = 8'h08;
   localparam logic [7:0] STS_HI_CONST = 8'h01;
   localparam logic [7:0] XST_LO_CONST = 8'h00;
   localparam logic [7:0] XST_HI_CONST = 8'h80;
   // expansion low byte
   localparam int B_PGRX = 1;
endpackage

// File: rtl/pcs_mgmt_host_if.sv
module pcs_mgmt_host_if (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic wr_n,
   output logic acc_stb,
   output logic acc_wr,
   output logic acc_rd,
   output logic rdy_n
);
   logic served;

   assign acc_stb = !cs_n && !served;
   assign acc_wr  = acc_stb && !wr_n;
   assign acc_rd  = acc_stb && wr_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         served <= 1'b0;
         rdy_n  <= 1'b1;
      end else begin
         if (cs_n)         served <= 1'b0;
         else if (acc_stb) served <= 1'b1;
         rdy_n <= !acc_stb;
      end
   end
endmodule

// File: rtl/pcs_mgmt_evt_latch.sv
module pcs_mgmt_evt_latch #(
   parameter bit HOLD_LOW = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic live,
   input  logic rd_clr,
   output logic held
);
   generate
      if (HOLD_LOW) begin : g_low
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      held <= 1'b0;
            else if (rd_clr) held <= live;
            else             held <= held & live;
         end
      end else begin : g_high
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      held <= 1'b0;
            else if (rd_clr) held <= live;
            else             held <= held | live;
         end
      end
   endgenerate
endmodule

// File: rtl/pcs_mgmt_ctl_regs.sv
module pcs_mgmt_ctl_regs
   import pcs_mgmt_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 8,
   parameter int ABIL_W    = 16,
   parameter bit AN_EN_RST = 1'b1,
   parameter logic [ABIL_W-1:0] ADV_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [7:0]        ctl_hi,
   output logic              unidir,
   output logic [ABIL_W-1:0] adv
);
   localparam int ADV_BYTES = ABIL_W / DATA_W;
   localparam logic [7:0] CTL_HI_RST = 8'(AN_EN_RST) << B_ANEN;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_hi <= CTL_HI_RST;
         unidir <= 1'b0;
      end else begin
         if (acc_wr && addr == ADDR_W'(A_CTL_HI)) ctl_hi <= wdata & CTL_HI_RW;
         else                                    ctl_hi <= ctl_hi & ~CTL_HI_SC;
         if (acc_wr && addr == ADDR_W'(A_CTL_LO)) unidir <= wdata[B_UNI];
      end
   end

   for (genvar b = 0; b < ADV_BYTES; b++) begin : g_adv
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            adv[b*DATA_W +: DATA_W] <= ADV_RST[b*DATA_W +: DATA_W];
         else if (acc_wr && addr == ADDR_W'(A_ADV_LO) + ADDR_W'(b))
            adv[b*DATA_W +: DATA_W] <= wdata;
      end
   end
endmodule

// File: rtl/pcs_mgmt_regs.sv
module pcs_mgmt_regs
   import pcs_mgmt_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 8,
   parameter int ABIL_W    = 16,
   parameter bit AN_EN_RST = 1'b1,
   parameter logic [ABIL_W-1:0] ADV_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_cs_n,
   input  logic              host_wr_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              host_rdy_n,
   output logic              ctl_reset,
   output logic              ctl_loopback,
   output logic              ctl_an_enable,
   output logic              ctl_power_down,
   output logic              ctl_isolate,
   output logic              ctl_an_restart,
   output logic              ctl_duplex,
   output logic              ctl_unidir,
   output logic [ABIL_W-1:0] adv_ability,
   input  logic              st_link_ok,
   input  logic              st_an_done,
   input  logic              st_page_rx,
   input  logic [ABIL_W-1:0] lp_ability
);
   initial begin
      if (DATA_W != 8)        $error("DATA_W must be 8");
      if (ADDR_W < MAP_AW)    $error("ADDR_W too small for map");
      if (ABIL_W != 2*DATA_W) $error("ABIL_W must span two bytes");
   end

   logic       acc_stb, acc_wr, acc_rd;
   logic [7:0] ctl_hi;
   logic       link_lat, page_lat;
   logic [DATA_W-1:0] rd_mux;

   pcs_mgmt_host_if i_hif (
      .clk(clk), .rst_n(rst_n), .cs_n(host_cs_n), .wr_n(host_wr_n),
      .acc_stb(acc_stb), .acc_wr(acc_wr), .acc_rd(acc_rd), .rdy_n(host_rdy_n)
   );

   pcs_mgmt_ctl_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ABIL_W(ABIL_W),
      .AN_EN_RST(AN_EN_RST), .ADV_RST(ADV_RST)
   ) i_ctl (
      .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .addr(host_addr),
      .wdata(host_wdata), .ctl_hi(ctl_hi), .unidir(ctl_unidir), .adv(adv_ability)
   );

   pcs_mgmt_evt_latch #(.HOLD_LOW(1'b1)) i_link (
      .clk(clk), .rst_n(rst_n), .live(st_link_ok),
      .rd_clr(acc_rd && host_addr == ADDR_W'(A_STS_LO)), .held(link_lat)
   );

   pcs_mgmt_evt_latch #(.HOLD_LOW(1'b0)) i_page (
      .clk(clk), .rst_n(rst_n), .live(st_page_rx),
      .rd_clr(acc_rd && host_addr == ADDR_W'(A_EXP_LO)), .held(page_lat)
   );

   assign ctl_reset      = ctl_hi[B_RST];
   assign ctl_loopback   = ctl_hi[B_LOOP];
   assign ctl_an_enable  = ctl_hi[B_ANEN];
   assign ctl_power_down = ctl_hi[B_PD];
   assign ctl_isolate    = ctl_hi[B_ISO];
   assign ctl_an_restart = ctl_hi[B_RSAN];
   assign ctl_duplex     = ctl_hi[B_DUP];

   always_comb begin
      rd_mux = '0;
      case (host_addr)
         ADDR_W'(A_CTL_LO): begin
            rd_mux        = CTL_LO_CONST;
            rd_mux[B_UNI] = ctl_unidir;
         end
         ADDR_W'(A_CTL_HI): rd_mux = ctl_hi;
         ADDR_W'(A_STS_LO): begin
            rd_mux         = STS_LO_CONST;
            rd_mux[B_LINK] = link_lat;
            rd_mux[B_AND]  = st_an_done;
         end
         ADDR_W'(A_STS_HI): rd_mux = STS_HI_CONST;
         ADDR_W'(A_ADV_LO): rd_mux = adv_ability[DATA_W-1:0];
         ADDR_W'(A_ADV_HI): rd_mux = adv_ability[ABIL_W-1:DATA_W];
         ADDR_W'(A_LP_LO):  rd_mux = lp_ability[DATA_W-1:0];
         ADDR_W'(A_LP_HI):  rd_mux = lp_ability[ABIL_W-1:DATA_W];
         ADDR_W'(A_EXP_LO): rd_mux[B_PGRX] = page_lat;
         ADDR_W'(A_XST_LO): rd_mux = XST_LO_CONST;
         ADDR_W'(A_XST_HI): rd_mux = XST_HI_CONST;
         default:           rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      host_rdata <= '0;
      else if (acc_rd) host_rdata <= rd_mux;
   end
endmodule

// File: rtl/pcs_mgmt_regs_chk.sv
module pcs_mgmt_regs_chk #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_cs_n,
   input logic              host_wr_n,
   input logic [ADDR_W-1:0] host_addr,
   input logic [DATA_W-1:0] host_rdata,
   input logic              host_rdy_n,
   input logic              ctl_reset,
   input logic              ctl_an_restart,
   input logic              st_link_ok,
   input logic              st_page_rx,
   input logic              link_lat,
   input logic              page_lat
);
   // R1: ready only follows a cycle with select low
   p_rdy_after_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !host_rdy_n |-> $past(!host_cs_n));
   // R1: ready lasts one cycle
   p_rdy_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !host_rdy_n |=> host_rdy_n);
   // R4: self-clearing reset
   p_rst_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_reset |=> !ctl_reset);
   // R4: self-clearing restart
   p_rsan_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_an_restart |=> !ctl_an_restart);
   // R8: link down clears the latch
   p_link_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !st_link_ok |=> !link_lat);
   // R10: a page event sets the latch
   p_page_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      st_page_rx |=> page_lat);
   // R2: extended status high reads constant
   p_xst_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_rdy_n && $past(host_wr_n) && $past(host_addr) == ADDR_W'(6'h1F))
      |-> host_rdata == DATA_W'(8'h80));
endmodule

bind pcs_mgmt_regs pcs_mgmt_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_wr_n(host_wr_n),
   .host_addr(host_addr), .host_rdata(host_rdata), .host_rdy_n(host_rdy_n),
   .ctl_reset(ctl_reset), .ctl_an_restart(ctl_an_restart),
   .st_link_ok(st_link_ok), .st_page_rx(st_page_rx),
   .link_lat(link_lat), .page_lat(page_lat)
);

// File: tb/test_pcs_mgmt_regs.sv
module test_pcs_mgmt_regs;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 22;
   // {wr, addr[5:0], wdata[7:0], expected read[7:0], check}
   localparam logic [23:0] VEC [NV] = '{
      {1'b0, 6'h02, 8'h00, 8'h08, 1'b1},  // R8 latched low since reset, R2 bit3
      {1'b0, 6'h02, 8'h00, 8'h0C, 1'b1},  // R8 reloaded from live
      {1'b0, 6'h03, 8'h00, 8'h01, 1'b1},  // R2
      {1'b0, 6'h1E, 8'h00, 8'h00, 1'b1},  // R2
      {1'b0, 6'h1F, 8'h00, 8'h80, 1'b1},  // R2
      {1'b0, 6'h0A, 8'h00, 8'hC3, 1'b1},  // R7
      {1'b0, 6'h0B, 8'h00, 8'hA5, 1'b1},  // R7
      {1'b0, 6'h01, 8'h00, 8'h10, 1'b1},  // R12 reset value
      {1'b0, 6'h00, 8'h00, 8'h40, 1'b1},  // R2 / R5
      {1'b1, 6'h01, 8'h7F, 8'h00, 1'b0},  // R3 write
      {1'b0, 6'h01, 8'h00, 8'h5D, 1'b1},  // R3 R4
      {1'b1, 6'h00, 8'hFF, 8'h00, 1'b0},  // R5 write
      {1'b0, 6'h00, 8'h00, 8'h60, 1'b1},  // R5
      {1'b1, 6'h08, 8'h21, 8'h00, 1'b0},  // R6
      {1'b1, 6'h09, 8'h80, 8'h00, 1'b0},  // R6
      {1'b0, 6'h08, 8'h00, 8'h21, 1'b1},  // R6
      {1'b0, 6'h09, 8'h00, 8'h80, 1'b1},  // R6
      {1'b1, 6'h02, 8'hFF, 8'h00, 1'b0},  // R11 write read-only
      {1'b0, 6'h02, 8'h00, 8'h0C, 1'b1},  // R11
      {1'b1, 6'h1F, 8'h00, 8'h00, 1'b0},  // R11 write constant
      {1'b0, 6'h1F, 8'h00, 8'h80, 1'b1},  // R11
      {1'b0, 6'h10, 8'h00, 8'h00, 1'b1}   // R11 unmapped
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic host_cs_n = 1'b1, host_wr_n = 1'b1;
   logic [5:0] host_addr = '0;
   logic [7:0] host_wdata = '0, host_rdata;
   logic host_rdy_n;
   logic ctl_reset, ctl_loopback, ctl_an_enable, ctl_power_down;
   logic ctl_isolate, ctl_an_restart, ctl_duplex, ctl_unidir;
   logic [15:0] adv_ability;
   logic st_link_ok = 1'b1, st_an_done = 1'b0, st_page_rx = 1'b0;
   logic [15:0] lp_ability = 16'hA5C3;

   int total = 0, bad = 0;
   logic [7:0] rd_val;
   logic rdy_seen, snap_rst, snap_rsan;
   bit   finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pcs_mgmt_regs i_pcs_mgmt_regs (
      .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_wr_n(host_wr_n),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_rdy_n(host_rdy_n), .ctl_reset(ctl_reset), .ctl_loopback(ctl_loopback),
      .ctl_an_enable(ctl_an_enable), .ctl_power_down(ctl_power_down),
      .ctl_isolate(ctl_isolate), .ctl_an_restart(ctl_an_restart),
      .ctl_duplex(ctl_duplex), .ctl_unidir(ctl_unidir), .adv_ability(adv_ability),
      .st_link_ok(st_link_ok), .st_an_done(st_an_done), .st_page_rx(st_page_rx),
      .lp_ability(lp_ability)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // starts and ends at a negedge, select high on exit
   task automatic xfer(input logic wr, input logic [5:0] a, input logic [7:0] d);
      host_cs_n = 1'b0; host_wr_n = !wr; host_addr = a; host_wdata = d;
      @(posedge clk); @(negedge clk);
      rdy_seen = !host_rdy_n; rd_val = host_rdata;
      snap_rst = ctl_reset; snap_rsan = ctl_an_restart;
      host_cs_n = 1'b1; host_wr_n = 1'b1;
      @(posedge clk); @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state
      check("R12 rdy_n", host_rdy_n, 1);
      check("R12 an_enable", ctl_an_enable, 1);
      check("R12 other ctl", {ctl_reset, ctl_loopback, ctl_power_down, ctl_isolate,
                              ctl_an_restart, ctl_duplex, ctl_unidir}, 0);
      check("R12 adv", adv_ability, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         xfer(VEC[i][23], VEC[i][22:17], VEC[i][16:9]);
         check("R1 ready", rdy_seen, 1);
         if (VEC[i][0]) check($sformatf("vector %0d R2-map", i), rd_val, VEC[i][8:1]);
      end
      check("R3 outputs", {ctl_loopback, ctl_an_enable, ctl_power_down, ctl_isolate,
                           ctl_duplex}, 5'b11111);
      check("R5 unidir", ctl_unidir, 1);
      check("R6 adv word", adv_ability, 16'h8021);

      // R4 self-clearing reset and restart
      xfer(1'b1, 6'h01, 8'h92);
      check("R4 reset pulse", snap_rst, 1);
      check("R4 restart pulse", snap_rsan, 1);
      check("R4 cleared", {ctl_reset, ctl_an_restart}, 2'b00);
      xfer(1'b0, 6'h01, 8'h00);
      check("R4 readback", rd_val, 8'h10);

      // R8 short link drop between reads
      st_link_ok = 1'b0; @(negedge clk); st_link_ok = 1'b1; @(negedge clk);
      xfer(1'b0, 6'h02, 8'h00);
      check("R8 drop seen", rd_val, 8'h08);
      xfer(1'b0, 6'h02, 8'h00);
      check("R8 recovered", rd_val, 8'h0C);
      // R8 link still down across reads
      st_link_ok = 1'b0; @(negedge clk);
      xfer(1'b0, 6'h02, 8'h00);
      check("R8 down read", rd_val, 8'h08);
      xfer(1'b0, 6'h02, 8'h00);
      check("R8 still down", rd_val, 8'h08);
      st_link_ok = 1'b1; @(negedge clk);

      // R9 live negotiation complete (latch has been reloaded low)
      st_an_done = 1'b1;
      xfer(1'b0, 6'h02, 8'h00);
      check("R9 an done", rd_val, 8'h28);
      st_an_done = 1'b0;

      // R10 page received pulse
      xfer(1'b0, 6'h0C, 8'h00);
      check("R10 idle", rd_val, 8'h00);
      st_page_rx = 1'b1; @(negedge clk); st_page_rx = 1'b0; @(negedge clk);
      xfer(1'b0, 6'h0C, 8'h00);
      check("R10 latched", rd_val, 8'h02);
      xfer(1'b0, 6'h0C, 8'h00);
      check("R10 cleared", rd_val, 8'h00);
      xfer(1'b0, 6'h0D, 8'h00);
      check("R10 high byte", rd_val, 8'h00);

      // R1 select held low: one access, one ready
      host_cs_n = 1'b0; host_wr_n = 1'b0; host_addr = 6'h08; host_wdata = 8'h55;
      @(posedge clk); @(negedge clk);
      check("R1 first ready", host_rdy_n, 0);
      host_wdata = 8'hAA;
      @(posedge clk); @(negedge clk);
      check("R1 no second ready", host_rdy_n, 1);
      @(posedge clk); @(negedge clk);
      check("R1 single write", adv_ability[7:0], 8'h55);
      host_cs_n = 1'b1; host_wr_n = 1'b1;
      @(negedge clk);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule